// File: doc/BRIEF.md
# Reciprocal Frequency Counter Core

This block measures an input signal against the reference clock with the reciprocal method. The measuring window always starts and ends on rising edges of the input. For each window it reports two whole numbers: the input cycles that fit in the window, and the reference cycles that the window lasted. No interpolation happens between reference edges, so the resolution is one reference period. A host divides one count by the other to get frequency or period.

One mode gives independent, back-to-back results, one for each selected gate time. The other mode gives a sliding result at a fixed cadence. It takes a snapshot of (rising edges seen, reference time of the latest edge) every cadence period. Each result is the difference between the newest snapshot and the snapshot that lies one gate time earlier. The input is synchronized into the reference domain inside the block. If the input falls silent for twice the gate time, the partial measurement is dropped and a flag is raised. All lengths are parameters in reference cycles, so a bench can scale them down.

Top module: `recip_counter`

## Requirements
- R1: While reset is applied and after it is released with no input, `res_valid` and `no_signal` are 0 and both count outputs are 0.
- R2: With `mode_sel`=0, a gate opens on the first input rising edge after arming. It closes on the first rising edge at which the reference cycles elapsed since opening are greater than or equal to the gate length. `res_cycles` is the number of rising edges after the opening edge, up to and including the closing edge. `res_ticks` is the number of reference cycles between the two edges.
- R3: With `mode_sel`=0, the closing edge of one gate is the opening edge of the next. Results therefore follow each other with no lost time, and the number of cycles between two consecutive valid strobes equals the later result's `res_ticks`.
- R4: `gate_sel` values 0, 1, 2 and 3 select gate lengths GATE0, GATE1, GATE2 and GATE3 reference cycles. In sliding mode the window spans S cadence periods, where S is the gate length divided by CADENCE, rounded down, with a minimum of 1.
- R5: With `mode_sel`=1, the first rising edge after arming starts a cadence timer. A snapshot is taken every CADENCE cycles after it. The snapshot holds the count of rising edges that arrived before that cycle, and the reference time of the latest such edge. An edge that lands in the snapshot cycle itself counts toward the next snapshot. The first result comes at snapshot S+1 and is the newest snapshot minus the snapshot S earlier. After that one result follows every CADENCE cycles.
- R6: If no rising edge arrives for twice the selected gate length, `no_signal` goes to 1, the partial measurement and the snapshot history are dropped, and no result is emitted. The next rising edge clears the flag and opens a fresh measurement.
- R7: Any change of `gate_sel` or `mode_sel` drops the partial measurement and the snapshot history. The first result afterwards therefore covers only edges that arrive after the change.
- R8: `res_valid` is a single-cycle strobe that never stays high for two consecutive cycles, and only one mode can produce a result in a given cycle. The counts on the outputs are meaningful during the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one count per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sig_in | input | 1 | Signal under measurement, asynchronous to clk |
| gate_sel | input | 2 | Gate length select |
| mode_sel | input | 1 | 0 = independent results, 1 = sliding results |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| res_cycles | output | 40 | Whole input cycles in the window |
| res_ticks | output | 40 | Whole reference cycles in the window |
| no_signal | output | 1 | Input has been silent for twice the gate length |

## Verification
In independent mode, the cycle that closes one gate is also the cycle that opens the next. An irregular edge pattern provokes this, including a gap exactly equal to the gate length and a gap one cycle short of it, and each count is compared against values worked out from the gaps. In sliding mode, a snapshot can fall on the same cycle as an input edge. Choosing an input period that divides the cadence makes every snapshot coincide with an edge. The bench then judges whether that edge is deferred to the following snapshot by comparing against a closed-form count of edges before each snapshot time. A configuration change landing on an open gate is judged by the first result after it, which must contain only fresh edges.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int CNT_W = 40;
  typedef logic [CNT_W-1:0] cnt_t;
  typedef enum logic {
    MODE_EVERY = 1'b0,
    MODE_SLIDE = 1'b1
  } mode_e;
endpackage

// File: rtl/rc_sync.sv
module rc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] st_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      st_q   <= {st_q[STAGES-2:0], async_i};
      prev_q <= st_q[STAGES-1];
    end
  end

  assign rise_o = st_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/rc_timebase.sv
module rc_timebase
  import rc_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic cfg_chg_i,
  input  cnt_t gate_len_i,
  output cnt_t ts_o,
  output cnt_t ev_o,
  output cnt_t tlast_o,
  output logic nosig_o,
  output logic clr_o
);
  cnt_t             ts_q, ev_q, ev_d, tlast_q, tlast_d;
  logic [CNT_W:0]   quiet_q, quiet_d, limit;
  logic             nosig_q, nosig_d, fire;

  assign limit = {gate_len_i, 1'b0} - (CNT_W+1)'(1);
  assign fire  = !nosig_q && !rise_i && !cfg_chg_i && (quiet_q >= limit);
  assign clr_o = cfg_chg_i | fire;

  always_comb begin
    ev_d    = ev_q;
    tlast_d = tlast_q;
    quiet_d = quiet_q;
    nosig_d = nosig_q;
    if (cfg_chg_i) begin
      ev_d    = '0;
      quiet_d = '0;
    end else if (fire) begin
      ev_d    = '0;
      nosig_d = 1'b1;
    end else if (rise_i) begin
      ev_d    = ev_q + 1'b1;
      tlast_d = ts_q;
      quiet_d = '0;
      nosig_d = 1'b0;
    end else if (!nosig_q) begin
      quiet_d = quiet_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q    <= '0;
      ev_q    <= '0;
      tlast_q <= '0;
      quiet_q <= '0;
      nosig_q <= 1'b0;
    end else begin
      ts_q    <= ts_q + 1'b1;
      ev_q    <= ev_d;
      tlast_q <= tlast_d;
      quiet_q <= quiet_d;
      nosig_q <= nosig_d;
    end
  end

  assign ts_o    = ts_q;
  assign ev_o    = ev_q;
  assign tlast_o = tlast_q;
  assign nosig_o = nosig_q;

  // R6: an accepted edge always releases the silence flag
  assert_nosig_release_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (nosig_q && rise_i && !cfg_chg_i) |=> !nosig_q);
  // R6: flag only rises after a long quiet stretch
  assert_nosig_quiet_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!nosig_q && rise_i) |=> !nosig_q);
endmodule

// File: rtl/rc_gate.sv
module rc_gate
  import rc_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic rise_i,
  input  cnt_t ts_i,
  input  cnt_t gate_len_i,
  output logic vld_o,
  output cnt_t cyc_o,
  output cnt_t tick_o
);
  logic open_q, open_d, vld_q, vld_d;
  cnt_t t_open_q, t_open_d, n_q, n_d, cyc_q, cyc_d, tick_q, tick_d;
  cnt_t span, n_inc;

  assign span  = ts_i - t_open_q;
  assign n_inc = n_q + 1'b1;

  always_comb begin
    open_d   = open_q;
    t_open_d = t_open_q;
    n_d      = n_q;
    cyc_d    = cyc_q;
    tick_d   = tick_q;
    vld_d    = 1'b0;
    if (clr_i || !en_i) begin
      open_d = 1'b0;
    end else if (rise_i) begin
      if (!open_q) begin
        open_d   = 1'b1;
        t_open_d = ts_i;
        n_d      = '0;
      end else if (span >= gate_len_i) begin
        vld_d    = 1'b1;
        cyc_d    = n_inc;
        tick_d   = span;
        t_open_d = ts_i;
        n_d      = '0;
      end else begin
        n_d = n_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q   <= 1'b0;
      t_open_q <= '0;
      n_q      <= '0;
      cyc_q    <= '0;
      tick_q   <= '0;
      vld_q    <= 1'b0;
    end else begin
      open_q   <= open_d;
      t_open_q <= t_open_d;
      n_q      <= n_d;
      cyc_q    <= cyc_d;
      tick_q   <= tick_d;
      vld_q    <= vld_d;
    end
  end

  assign vld_o  = vld_q;
  assign cyc_o  = cyc_q;
  assign tick_o = tick_q;

  // R2: a closed gate spans at least the selected length
  assert_gate_span_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    vld_q |-> (tick_q >= gate_len_i));
  // R2: a closed gate holds at least one whole input cycle
  assert_gate_cycles_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    vld_q |-> (cyc_q != '0));
  // R8: strobe lasts one cycle
  assert_gate_pulse_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    vld_q |=> !vld_q);
endmodule

// File: rtl/rc_window.sv
module rc_window
  import rc_pkg::*;
#(
  parameter int CAD   = 100_000_000,
  parameter int DEPTH = 51
) (
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       clr_i,
  input  logic                       rise_i,
  input  cnt_t                       ev_i,
  input  cnt_t                       tlast_i,
  input  logic [$clog2(DEPTH+1)-1:0] slots_i,
  output logic                       vld_o,
  output cnt_t                       cyc_o,
  output cnt_t                       tick_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int SW = $clog2(DEPTH+1);
  localparam int CW = $clog2(CAD+1);

  cnt_t ring_ev [DEPTH];
  cnt_t ring_t  [DEPTH];

  logic          act_q, act_d, vld_q, vld_d, we, snap, full;
  logic [CW-1:0] cad_q, cad_d;
  logic [AW-1:0] wp_q, wp_d, wp_next, rp;
  logic [SW-1:0] fill_q, fill_d;
  cnt_t          cyc_q, cyc_d, tick_q, tick_d;
  int            rp_i;

  assign snap    = act_q && (cad_q == CW'(CAD));
  assign full    = fill_q >= slots_i;
  assign wp_next = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;

  always_comb begin
    rp_i = int'(wp_q) - int'(slots_i);
    if (rp_i < 0) rp_i = rp_i + DEPTH;
    rp = AW'(rp_i);
  end

  always_comb begin
    act_d  = act_q;
    cad_d  = cad_q;
    wp_d   = wp_q;
    fill_d = fill_q;
    cyc_d  = cyc_q;
    tick_d = tick_q;
    vld_d  = 1'b0;
    we     = 1'b0;
    if (clr_i || !en_i) begin
      act_d  = 1'b0;
      fill_d = '0;
      wp_d   = '0;
    end else if (!act_q) begin
      if (rise_i) begin
        act_d = 1'b1;
        cad_d = CW'(1);
      end
    end else if (snap) begin
      we    = 1'b1;
      wp_d  = wp_next;
      cad_d = CW'(1);
      if (!full) begin
        fill_d = fill_q + 1'b1;
      end else begin
        vld_d  = 1'b1;
        cyc_d  = ev_i - ring_ev[rp];
        tick_d = tlast_i - ring_t[rp];
      end
    end else begin
      cad_d = cad_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      cad_q  <= '0;
      wp_q   <= '0;
      fill_q <= '0;
      cyc_q  <= '0;
      tick_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      cad_q  <= cad_d;
      wp_q   <= wp_d;
      fill_q <= fill_d;
      cyc_q  <= cyc_d;
      tick_q <= tick_d;
      vld_q  <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      ring_ev[wp_q] <= ev_i;
      ring_t[wp_q]  <= tlast_i;
    end
  end

  assign vld_o  = vld_q;
  assign cyc_o  = cyc_q;
  assign tick_o = tick_q;

  // R5: a sliding result appears only once the history reaches the window
  assert_slide_fill_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    vld_q |-> (fill_q == slots_i));
  // R8: strobe lasts one cycle
  assert_slide_pulse_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    vld_q |=> !vld_q);
endmodule

// File: rtl/recip_counter.sv
module recip_counter
  import rc_pkg::*;
#(
  parameter longint GATE0       = 64'd15_000_000,
  parameter longint GATE1       = 64'd50_000_000,
  parameter longint GATE2       = 64'd500_000_000,
  parameter longint GATE3       = 64'd5_000_000_000,
  parameter int     CADENCE     = 100_000_000,
  parameter int     SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sig_in,
  input  logic [1:0]           gate_sel,
  input  logic                 mode_sel,
  output logic                 res_valid,
  output logic [CNT_W-1:0]     res_cycles,
  output logic [CNT_W-1:0]     res_ticks,
  output logic                 no_signal
);
  function automatic longint slots_of(longint g);
    return (g / CADENCE < 1) ? 64'd1 : g / CADENCE;
  endfunction

  function automatic longint max4(longint a, longint b, longint c, longint d);
    longint m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  localparam int DEPTH = int'(slots_of(max4(GATE0, GATE1, GATE2, GATE3))) + 1;
  localparam int SW    = $clog2(DEPTH+1);

  logic [1:0]    rst_q;
  logic          rst_i;
  logic [1:0]    gate_q;
  logic          mode_q, cfg_chg, rise, nosig, clr, en_every;
  cnt_t          gate_len, ts, ev, tlast, g_cyc, g_tick, w_cyc, w_tick;
  logic [SW-1:0] slots;
  logic          g_vld, w_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      gate_q <= 2'd0;
      mode_q <= 1'b0;
    end else begin
      gate_q <= gate_sel;
      mode_q <= mode_sel;
    end
  end
  assign cfg_chg  = (gate_sel != gate_q) || (mode_sel != mode_q);
  assign en_every = (mode_e'(mode_sel) == MODE_EVERY);

  always_comb begin
    case (gate_sel)
      2'd0:    begin gate_len = CNT_W'(GATE0); slots = SW'(slots_of(GATE0)); end
      2'd1:    begin gate_len = CNT_W'(GATE1); slots = SW'(slots_of(GATE1)); end
      2'd2:    begin gate_len = CNT_W'(GATE2); slots = SW'(slots_of(GATE2)); end
      default: begin gate_len = CNT_W'(GATE3); slots = SW'(slots_of(GATE3)); end
    endcase
  end

  rc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_ni(rst_i), .async_i(sig_in), .rise_o(rise)
  );

  rc_timebase u_tb (
    .clk(clk), .rst_ni(rst_i), .rise_i(rise), .cfg_chg_i(cfg_chg),
    .gate_len_i(gate_len), .ts_o(ts), .ev_o(ev), .tlast_o(tlast),
    .nosig_o(nosig), .clr_o(clr)
  );

  rc_gate u_gate (
    .clk(clk), .rst_ni(rst_i), .en_i(en_every), .clr_i(clr), .rise_i(rise),
    .ts_i(ts), .gate_len_i(gate_len), .vld_o(g_vld), .cyc_o(g_cyc), .tick_o(g_tick)
  );

  rc_window #(.CAD(CADENCE), .DEPTH(DEPTH)) u_win (
    .clk(clk), .rst_ni(rst_i), .en_i(!en_every), .clr_i(clr), .rise_i(rise),
    .ev_i(ev), .tlast_i(tlast), .slots_i(slots),
    .vld_o(w_vld), .cyc_o(w_cyc), .tick_o(w_tick)
  );

  assign res_valid  = g_vld | w_vld;
  assign res_cycles = w_vld ? w_cyc  : g_cyc;
  assign res_ticks  = w_vld ? w_tick : g_tick;
  assign no_signal  = nosig;

  // R8: the two result sources never fire together
  assert_one_source_R8: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0({g_vld, w_vld}));
endmodule

// File: tb/recip_counter_bench.sv
module recip_counter_bench;
  localparam longint G0 = 30, G1 = 100, G2 = 200, G3 = 400;
  localparam int     CAD = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sig;
  logic [1:0]  gate_sel = 2'd0;
  logic        mode_sel = 1'b0;
  logic        res_valid, no_signal;
  logic [39:0] res_cycles, res_ticks;

  recip_counter #(.GATE0(G0), .GATE1(G1), .GATE2(G2), .GATE3(G3), .CADENCE(CAD)) u_recip_counter (
    .clk(clk), .rst_n(rst_n), .sig_in(sig), .gate_sel(gate_sel), .mode_sel(mode_sel),
    .res_valid(res_valid), .res_cycles(res_cycles), .res_ticks(res_ticks), .no_signal(no_signal)
  );

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  int cyc_count = 0;

  // stimulus generator: one-cycle pulses, periodic or from a gap list
  logic gen_en = 1'b0, gen_pat = 1'b0;
  int   gen_p = 7;
  int   pat [16];
  int   pat_n = 0;
  int   phase = 0, pidx = 0, gap;
  bit   done = 0;

  always @(negedge clk) begin
    if (!gen_en) begin
      sig = 1'b0; phase = 0; pidx = 0; done = 0;
    end else begin
      if (phase == 0 && !done) begin
        sig = 1'b1;
        if (gen_pat && pidx == pat_n) done = 1;
      end else begin
        sig = 1'b0;
      end
      phase++;
      gap = (gen_pat && pidx < pat_n) ? pat[pidx] : gen_p;
      if (phase >= gap) begin
        phase = 0;
        if (gen_pat && pidx < pat_n) pidx++;
      end
    end
  end

  // result monitor
  longint r_cyc [128];
  longint r_tick [128];
  int     r_at [128];
  int     n_res = 0;
  int     back_to_back = 0;
  bit     prev_vld = 0;

  always @(posedge clk) cyc_count++;

  always @(negedge clk) begin
    if (res_valid) begin
      if (n_res < 128) begin
        r_cyc[n_res]  = longint'(res_cycles);
        r_tick[n_res] = longint'(res_ticks);
        r_at[n_res]   = cyc_count;
        n_res++;
      end
      if (prev_vld) back_to_back++;
    end
    prev_vld = res_valid;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic setup(input logic mode, input logic [1:0] sel);
    @(posedge clk); #1 gen_en = 1'b0;
    idle(5);
    #1 mode_sel = ~mode;
    idle(2);
    #1 mode_sel = mode; gate_sel = sel;
    idle(5);
  endtask

  task automatic start_periodic(input int p);
    @(posedge clk); #1 gen_pat = 1'b0; gen_p = p; gen_en = 1'b1;
  endtask

  task automatic wait_res(input int target, input int lim);
    int k = 0;
    while (n_res < target && k < lim) begin
      @(posedge clk);
      k++;
    end
    @(negedge clk);
  endtask

  function automatic longint snap_cnt(input int j, input int p);
    if (j == 0) return 0;
    return longint'((j*CAD - 1) / p + 1);
  endfunction

  function automatic longint snap_t(input int j, input int p);
    return longint'(p * ((j*CAD - 1) / p));
  endfunction

  task automatic t_reset;
    rst_n = 1'b0;
    idle(4);
    @(negedge clk);
    chk("R1 valid in reset", res_valid, 0);
    chk("R1 flag in reset", no_signal, 0);
    chk("R1 cycles in reset", res_cycles, 0);
    chk("R1 ticks in reset", res_ticks, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    idle(10);
    @(negedge clk);
    chk("R1 valid after release", res_valid, 0);
    chk("R1 flag after release", no_signal, 0);
  endtask

  task automatic t_every(input logic [1:0] sel, input longint g, input int p);
    int base;
    longint k;
    setup(1'b0, sel);
    base = n_res;
    start_periodic(p);
    wait_res(base + 3, int'(4*g) + 200);
    chk("R2 result count", n_res - base, 3);
    k = (g + p - 1) / p;
    for (int i = 0; i < 3; i++) begin
      chk("R2 R4 input cycles", r_cyc[base+i], k);
      chk("R2 R4 reference cycles", r_tick[base+i], k * p);
    end
    for (int i = 1; i < 3; i++)
      chk("R3 no dead time between gates", longint'(r_at[base+i] - r_at[base+i-1]), r_tick[base+i]);
  endtask

  task automatic t_pattern;
    int base;
    int gaps [8] = '{13, 9, 17, 11, 25, 30, 29, 2};
    longint ec [4] = '{3, 2, 1, 2};
    longint et [4] = '{39, 36, 30, 31};
    setup(1'b0, 2'd0);
    base = n_res;
    @(posedge clk); #1;
    for (int i = 0; i < 8; i++) pat[i] = gaps[i];
    pat_n = 8; gen_pat = 1'b1; gen_en = 1'b1;
    wait_res(base + 4, 400);
    chk("R2 irregular result count", n_res - base, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R2 irregular cycles", r_cyc[base+i], ec[i]);
      chk("R2 irregular ticks (gap equal to gate closes)", r_tick[base+i], et[i]);
    end
  endtask

  task automatic t_slide(input logic [1:0] sel, input int s, input int p);
    int base, j;
    setup(1'b1, sel);
    base = n_res;
    start_periodic(p);
    wait_res(base + 3, (s + 6) * CAD + 100);
    chk("R5 sliding result count", n_res - base, 3);
    for (int i = 0; i < 3; i++) begin
      j = s + 1 + i;
      chk("R5 R4 sliding cycles", r_cyc[base+i], snap_cnt(j, p) - snap_cnt(j - s, p));
      chk("R5 R4 sliding ticks", r_tick[base+i], snap_t(j, p) - snap_t(j - s, p));
    end
    for (int i = 1; i < 3; i++)
      chk("R5 cadence spacing", longint'(r_at[base+i] - r_at[base+i-1]), CAD);
  endtask

  task automatic t_nosig;
    int base;
    setup(1'b0, 2'd0);
    start_periodic(7);
    wait_res(n_res + 2, 400);
    @(posedge clk); #1 gen_en = 1'b0;
    idle(5);
    base = n_res;
    idle(int'(2*G0) + 20);
    @(negedge clk);
    chk("R6 flag after silence", no_signal, 1);
    chk("R6 no result during silence", n_res - base, 0);
    start_periodic(7);
    idle(6);
    @(negedge clk);
    chk("R6 flag released by edge", no_signal, 0);
    wait_res(base + 1, 400);
    chk("R6 fresh gate cycles", r_cyc[base], 5);
    chk("R6 fresh gate ticks", r_tick[base], 35);
  endtask

  task automatic t_cfg;
    int base, at_chg;
    setup(1'b0, 2'd3);
    start_periodic(7);
    idle(150);
    base = n_res;
    @(posedge clk); #1 gate_sel = 2'd0;
    wait_res(base + 1, 400);
    chk("R7 partial gate dropped: cycles", r_cyc[base], 5);
    chk("R7 partial gate dropped: ticks", r_tick[base], 35);
    setup(1'b1, 2'd1);
    start_periodic(7);
    wait_res(n_res + 1, 400);
    base = n_res;
    @(posedge clk); #1 gate_sel = 2'd2; at_chg = cyc_count;
    wait_res(base + 1, 600);
    chk("R7 history cleared: result latency", longint'(r_at[base] - at_chg >= 11*CAD), 1);
    chk("R7 history cleared: cycles", r_cyc[base], snap_cnt(11, 7) - snap_cnt(1, 7));
    chk("R7 history cleared: ticks", r_tick[base], snap_t(11, 7) - snap_t(1, 7));
  endtask

  initial begin
    #(200000 * 10);
    tests++; fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_every(2'd0, G0, 7);
    t_every(2'd1, G1, 7);
    t_every(2'd2, G2, 9);
    t_every(2'd3, G3, 13);
    t_pattern();
    t_slide(2'd1, 5, 7);
    t_slide(2'd0, 1, 5);   // edges land on snapshot cycles
    t_slide(2'd2, 10, 5);
    t_slide(2'd3, 20, 13);
    t_nosig();
    t_cfg();
    chk("R8 strobe never two cycles long", back_to_back, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule